// File: doc/BRIEF.md
# Serial DAC Frame Controller

This block sits on the host side of a 14-bit serial-input voltage DAC. It takes a code through a valid/ready handshake and turns it into one 16-bit serial frame. The frame carries the code most significant bit first and ends with two zero pad bits. The block drives an active-low chip select, a serial clock that idles low, a data line that changes on the falling clock edge, and an active-low load strobe.

A code is committed in one of two ways, chosen per frame when the code is accepted. In chip-select commit mode the word takes effect when chip select rises and the load strobe stays high. In strobe commit mode a separate low pulse on the load strobe commits the word once chip select is high. A second per-frame option converts a signed two's-complement input to offset binary for bipolar output by inverting bit 13.

All intervals are counted in system clock cycles, rounded up from nanosecond parameters and the system clock frequency: serial clock phases, chip-select setup and hold, strobe setup and width, a minimum chip-select high time between frames, and a power-up lockout after reset.

Top module: `sdac_frame_ctrl`

## Requirements
- R1: Each frame shifts 16 bits: code bit 13 first down to bit 0, then two zero bits. Data is sampled on rising serial clock edges, changes only together with a falling edge or while chip select is high, and holds steady while the clock is high.
- R2: The serial clock idles low and toggles only while chip select is low. Every high phase and every low phase between rising edges lasts exactly HALF cycles (10 at the defaults, 50 ns at 200 MHz), so the rate never exceeds 10 MHz.
- R3: Chip select falls exactly LEAD cycles (10) before the first rising clock edge, and rises exactly TAIL cycles (9) after the last falling clock edge. The clock is low whenever chip select changes.
- R4: In strobe commit mode (cfg_strobe = 1 at acceptance) the load strobe stays high while chip select is low, then goes low exactly LDS cycles (10) after chip select rises and stays low for exactly LDW cycles (10).
- R5: In chip-select commit mode (cfg_strobe = 0 at acceptance) the load strobe stays high for the whole frame.
- R6: With cfg_bipolar = 1 at acceptance the code is sent with bit 13 inverted (signed 0x2000, i.e. -8192, gives 0x0000; 0x0000 gives 0x2000; 0x1FFF gives 0x3FFF). With cfg_bipolar = 0 the code is sent unchanged.
- R7: After reset is released, code_ready stays low and chip select stays high for exactly PWRUP cycles (4000, i.e. 20 us).
- R8: code_ready drops in the cycle after a code is accepted (code_valid high while code_ready is high) and returns after LEAD + 31*HALF + TAIL + GAP cycles (369 at defaults), where GAP (40, two serial clock periods) is the chip-select high time that also contains the strobe pulse. Changes on code_data, cfg_bipolar and cfg_strobe while busy have no effect on the frame in progress.
- R9: While reset is low the outputs are chip select high, clock low, data low, strobe high and code_ready low, including when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_valid | input | 1 | A code is offered |
| code_data | input | 14 | Code to send, unsigned or signed per cfg_bipolar |
| cfg_bipolar | input | 1 | Convert signed input to offset binary for this frame |
| cfg_strobe | input | 1 | Commit this frame with the load strobe instead of chip select |
| code_ready | output | 1 | Block can accept a code |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data to the converter |
| dac_ld_n | output | 1 | Active-low load strobe |

## Verification
On every cycle the assertions check the pin relations that hold regardless of timing: the clock and the strobe only move while chip select is in the right state, data stays steady through each high phase, each high phase is wide enough, chip select never changes with the clock high, the strobe only pulses in strobe mode, and code_ready stays low through the power-up lockout and the frame. The exact interval lengths, the bit order and pad bits, the bipolar mapping, the return of code_ready and the rejection of input changes while busy can only be shown by the bench scenarios, which send codes in both commit modes and both mappings, measure each interval and compare every pin against a cycle-level reference model, including a reset that cuts a frame short.

// File: rtl/sdac_pkg.sv
// Shared types and helpers for the serial DAC frame controller.
// Assumes nanosecond values and clock frequencies small enough that
// ns * MHz fits in 32 bits.
package sdac_pkg;

    // Nanoseconds to system clock cycles, rounded up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Sequencer phases of one frame.
    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } sdac_state_e;

    // Registered pin bundle towards the converter.
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdo;
        logic ld_n;
    } sdac_pins_t;

endpackage

// File: rtl/sdac_code_map.sv
// Builds the serial word from a code: optional bipolar conversion by
// inverting the code MSB, then SUB_W zero pad bits appended below.
// Purely combinational; assumes CODE_W >= 2.
module sdac_code_map #(
    parameter int unsigned CODE_W  = 14,
    parameter int unsigned SUB_W   = 2,
    localparam int unsigned FRAME_W = CODE_W + SUB_W
) (
    input  logic [CODE_W-1:0]  code,
    input  logic               bipolar,
    output logic [FRAME_W-1:0] word
);
    logic [CODE_W-1:0] msb_flip;

    // Mask that flips only the top code bit in bipolar mode.
    always_comb begin
        msb_flip = '0;
        msb_flip[CODE_W-1] = bipolar;
    end

    // Offset-binary code followed by zero pad bits.
    always_comb begin
        word = {code ^ msb_flip, {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/sdac_phase_timer.sv
// Down-counter that times each phase. A load of N-1 makes the current
// phase last N cycles; done is high in the last cycle. Comes out of
// reset loaded with RST_VAL so the first phase is the power-up wait.
module sdac_phase_timer #(
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdac_frame_shifter.sv
// Holds the frame word and presents its MSB as the next serial bit.
// Shifts left once per completed clock period and flags the last bit.
module sdac_frame_shifter #(
    parameter int unsigned FRAME_W = 16,
    localparam int unsigned IDX_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    input  logic               shift,
    output logic               msb,
    output logic               last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [IDX_W-1:0]   idx;

    // Shift register for the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= word;
        end else if (shift) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

    // Index of the bit currently on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= '0;
        end else if (shift) begin
            idx <= idx + 1'b1;
        end
    end

    assign msb  = shreg[FRAME_W-1];
    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/sdac_frame_ctrl.sv
// Host-side frame controller for a 14-bit serial-input DAC.
// Accepts a code on valid/ready, waits out a power-up lockout after
// reset, then sends lead, 16 clock periods, tail and an inter-frame gap
// in which an optional load strobe pulse commits the word. All pins are
// registered. Assumes GAP is long enough to hold the strobe setup and
// pulse, which the derived localparams guarantee.
module sdac_frame_ctrl #(
    parameter int unsigned SYS_MHZ          = 200,
    parameter int unsigned CODE_W           = 14,
    parameter int unsigned SUB_W            = 2,
    parameter int unsigned SCLK_PERIOD_NS   = 100,
    parameter int unsigned SCLK_PHASE_NS    = 45,
    parameter int unsigned CS_SETUP_NS      = 45,
    parameter int unsigned CS_HOLD_NS       = 45,
    parameter int unsigned LD_SETUP_NS      = 50,
    parameter int unsigned LD_WIDTH_NS      = 50,
    parameter int unsigned PWRUP_NS         = 20000,
    parameter int unsigned GAP_SCLK_PERIODS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_data,
    input  logic              cfg_bipolar,
    input  logic              cfg_strobe,
    output logic              code_ready,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              dac_ld_n
);
    import sdac_pkg::*;

    localparam int unsigned FRAME_W   = CODE_W + SUB_W;
    localparam int unsigned HALF_CYC  = max2(ns_to_cyc(SCLK_PHASE_NS, SYS_MHZ),
                                             ns_to_cyc((SCLK_PERIOD_NS + 1) / 2, SYS_MHZ));
    localparam int unsigned LEAD_CYC  = max2(ns_to_cyc(CS_SETUP_NS, SYS_MHZ), HALF_CYC);
    localparam int unsigned TAIL_CYC  = max2(ns_to_cyc(CS_HOLD_NS, SYS_MHZ), 1);
    localparam int unsigned LDS_CYC   = max2(ns_to_cyc(LD_SETUP_NS, SYS_MHZ), 1);
    localparam int unsigned LDW_CYC   = max2(ns_to_cyc(LD_WIDTH_NS, SYS_MHZ), 1);
    localparam int unsigned GAP_CYC   = max2(2 * GAP_SCLK_PERIODS * HALF_CYC, LDS_CYC + LDW_CYC + 1);
    localparam int unsigned PWRUP_CYC = max2(ns_to_cyc(PWRUP_NS, SYS_MHZ), 1);
    localparam int unsigned MAX_CYC   = max2(max2(PWRUP_CYC, GAP_CYC), max2(LEAD_CYC, max2(HALF_CYC, TAIL_CYC)));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] STB_HI  = CNT_W'(GAP_CYC - 1 - LDS_CYC);
    localparam logic [CNT_W-1:0] STB_LO  = CNT_W'(GAP_CYC - LDS_CYC - LDW_CYC);

    sdac_state_e        state_q, state_d;
    sdac_pins_t         pins_q, pins_d;
    logic [CNT_W-1:0]   cnt;
    logic               t_done;
    logic               t_load;
    logic [CNT_W-1:0]   t_val;
    logic               accept;
    logic               shift;
    logic               bit_msb;
    logic               bit_last;
    logic               strobe_q;
    logic [FRAME_W-1:0] word;

    // Code to frame word conversion.
    sdac_code_map #(
        .CODE_W (CODE_W),
        .SUB_W  (SUB_W)
    ) map_i (
        .code    (code_data),
        .bipolar (cfg_bipolar),
        .word    (word)
    );

    // Phase timer, starts in the power-up wait.
    sdac_phase_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .cnt      (cnt),
        .done     (t_done)
    );

    // Outgoing word and bit position.
    sdac_frame_shifter #(
        .FRAME_W (FRAME_W)
    ) shift_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .word  (word),
        .shift (shift),
        .msb   (bit_msb),
        .last  (bit_last)
    );

    // Next phase, timer reloads and shifter controls.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        shift   = 1'b0;
        case (state_q)
            ST_PWRUP: begin
                if (t_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (code_valid) begin
                    state_d = ST_LEAD;
                    t_load  = 1'b1;
                    t_val   = LEAD_LD;
                    accept  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (t_done) begin
                    state_d = ST_HIGH;
                    t_load  = 1'b1;
                    t_val   = HALF_LD;
                end
            end
            ST_HIGH: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (bit_last) begin
                        state_d = ST_TAIL;
                        t_val   = TAIL_LD;
                    end else begin
                        state_d = ST_LOW;
                        t_val   = HALF_LD;
                        shift   = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (t_done) begin
                    state_d = ST_HIGH;
                    t_load  = 1'b1;
                    t_val   = HALF_LD;
                end
            end
            ST_TAIL: begin
                if (t_done) begin
                    state_d = ST_GAP;
                    t_load  = 1'b1;
                    t_val   = GAP_LD;
                end
            end
            ST_GAP: begin
                if (t_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    // Commit mode latched with each accepted code.
    always_ff @(posedge clk) begin
        if (!rst_n)      strobe_q <= 1'b0;
        else if (accept) strobe_q <= cfg_strobe;
    end

    // Pin values implied by the current phase.
    always_comb begin
        pins_d.cs_n = 1'b1;
        pins_d.sclk = 1'b0;
        pins_d.sdo  = 1'b0;
        pins_d.ld_n = 1'b1;
        case (state_q)
            ST_LEAD, ST_LOW: begin
                pins_d.cs_n = 1'b0;
                pins_d.sdo  = bit_msb;
            end
            ST_HIGH: begin
                pins_d.cs_n = 1'b0;
                pins_d.sclk = 1'b1;
                pins_d.sdo  = bit_msb;
            end
            ST_TAIL: pins_d.cs_n = 1'b0;
            ST_GAP:  pins_d.ld_n = ~(strobe_q && (cnt <= STB_HI) && (cnt >= STB_LO));
            default: ;
        endcase
    end

    // Glitch-free registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '{cs_n: 1'b1, sclk: 1'b0, sdo: 1'b0, ld_n: 1'b1};
        else        pins_q <= pins_d;
    end

    assign code_ready = (state_q == ST_IDLE);
    assign dac_cs_n   = pins_q.cs_n;
    assign dac_sclk   = pins_q.sclk;
    assign dac_sdo    = pins_q.sdo;
    assign dac_ld_n   = pins_q.ld_n;
endmodule

// File: rtl/sdac_frame_ctrl_chk.sv
// Pin-level protocol checker for sdac_frame_ctrl, attached by bind.
// Observes only ports; keeps its own counters for width windows.
module sdac_frame_ctrl_chk #(
    parameter int unsigned HALF_CYC  = 10,
    parameter int unsigned PWRUP_CYC = 4000
) (
    input logic clk,
    input logic rst_n,
    input logic code_valid,
    input logic code_ready,
    input logic cfg_strobe,
    input logic dac_cs_n,
    input logic dac_sclk,
    input logic dac_sdo,
    input logic dac_ld_n
);
    int unsigned hi_cnt;
    int unsigned pw_cnt;
    logic        mode_q;

    // Consecutive cycles with the serial clock high.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_cnt <= 0;
        else if (dac_sclk) hi_cnt <= hi_cnt + 1;
        else               hi_cnt <= 0;
    end

    // Cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pw_cnt <= 0;
        else if (pw_cnt < PWRUP_CYC) pw_cnt <= pw_cnt + 1;
    end

    // Commit mode seen at the last handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mode_q <= 1'b0;
        else if (code_valid && code_ready) mode_q <= cfg_strobe;
    end

    assert_sdo_steady_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));

    assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> !dac_cs_n);

    assert_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> (hi_cnt >= HALF_CYC));

    assert_cs_fall_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> !dac_sclk);

    assert_cs_rise_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> !dac_sclk);

    assert_strobe_cs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> dac_cs_n);

    assert_strobe_mode_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> mode_q);

    assert_pwrup_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_cnt < PWRUP_CYC) |-> (!code_ready && dac_cs_n));

    assert_busy_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> !code_ready);
endmodule

bind sdac_frame_ctrl sdac_frame_ctrl_chk #(
    .HALF_CYC  (HALF_CYC),
    .PWRUP_CYC (PWRUP_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .cfg_strobe (cfg_strobe),
    .dac_cs_n   (dac_cs_n),
    .dac_sclk   (dac_sclk),
    .dac_sdo    (dac_sdo),
    .dac_ld_n   (dac_ld_n)
);

// File: tb/sdac_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdac_frame_ctrl_tb_top;

    function automatic int cdiv(input int ns);
        return (ns * 200 + 999) / 1000;
    endfunction

    localparam int HALF_C  = 10;
    localparam int LEAD_C  = 10;
    localparam int TAIL_C  = 9;
    localparam int LDS_C   = 10;
    localparam int LDW_C   = 10;
    localparam int GAP_C   = 40;
    localparam int PWR_C   = 4000;
    localparam int TOTAL_C = LEAD_C + 31 * HALF_C + TAIL_C + GAP_C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic [13:0] code_data = '0;
    logic        cfg_bipolar = 1'b0;
    logic        cfg_strobe = 1'b0;
    logic        code_ready, dac_cs_n, dac_sclk, dac_sdo, dac_ld_n;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdac_frame_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_valid  (code_valid),
        .code_data   (code_data),
        .cfg_bipolar (cfg_bipolar),
        .cfg_strobe  (cfg_strobe),
        .code_ready  (code_ready),
        .dac_cs_n    (dac_cs_n),
        .dac_sclk    (dac_sclk),
        .dac_sdo     (dac_sdo),
        .dac_ld_n    (dac_ld_n)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (per cycle) ----------------
    int          m_phase;   // 0 power-up, 1 idle, 2 busy
    int          m_cnt, m_t;
    logic [15:0] m_word;
    logic        m_strb;
    logic        e_cs, e_sclk, e_sdo, e_ld, e_rdy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_t = 0; m_word = '0; m_strb = 1'b0;
            e_cs = 1'b1; e_sclk = 1'b0; e_sdo = 1'b0; e_ld = 1'b1;
        end else begin
            e_cs = 1'b1; e_sclk = 1'b0; e_sdo = 1'b0; e_ld = 1'b1;
            if (m_phase == 2) begin
                if (m_t < LEAD_C) begin
                    e_cs = 1'b0; e_sdo = m_word[15];
                end else if (m_t < LEAD_C + 31 * HALF_C) begin
                    int u, k;
                    u = m_t - LEAD_C;
                    k = u / (2 * HALF_C);
                    e_cs = 1'b0;
                    if ((u % (2 * HALF_C)) < HALF_C) begin
                        e_sclk = 1'b1; e_sdo = m_word[15 - k];
                    end else begin
                        e_sdo = m_word[14 - k];
                    end
                end else if (m_t < LEAD_C + 31 * HALF_C + TAIL_C) begin
                    e_cs = 1'b0;
                end else begin
                    int e;
                    e = m_t - (LEAD_C + 31 * HALF_C + TAIL_C);
                    e_ld = !(m_strb && e >= LDS_C && e < LDS_C + LDW_C);
                end
            end
            case (m_phase)
                0: begin m_cnt++; if (m_cnt == PWR_C) m_phase = 1; end
                1: if (code_valid) begin
                       m_phase = 2; m_t = 0; m_strb = cfg_strobe;
                       m_word = {cfg_bipolar ? (code_data ^ 14'h2000) : code_data, 2'b00};
                   end
                default: begin m_t++; if (m_t == TOTAL_C) m_phase = 1; end
            endcase
        end
        e_rdy = (m_phase == 1);
    end

    // Compare every pin against the model on every cycle.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(dac_cs_n == e_cs,   "R3", "model cs_n",  dac_cs_n, e_cs);
            chk(dac_sclk == e_sclk, "R2", "model sclk",  dac_sclk, e_sclk);
            chk(dac_sdo == e_sdo,   "R1", "model sdo",   dac_sdo,  e_sdo);
            chk(dac_ld_n == e_ld,   "R4", "model ld_n",  dac_ld_n, e_ld);
            chk(code_ready == e_rdy, "R8", "model ready", code_ready, e_rdy);
        end
    end

    // ---------------- pin monitor ----------------
    logic [15:0] exp_q[$];
    bit          exp_s_q[$];
    int   cyc_n = 0, nbits = 0, nfr = 0, ld_lows = 0;
    int   t_csf = 0, t_csr = 0, t_sr = 0, t_sf = 0, t_lf = 0;
    logic [15:0] cap = '0;
    bit   cur_s = 1'b0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_ld = 1'b1;

    always @(negedge clk) begin
        cyc_n++;
        if (!rst_n) begin
            nbits = 0; nfr = 0;
        end else begin
            if (!dac_ld_n) ld_lows++;
            if (!dac_cs_n && p_cs) begin
                if (nfr > 0) chk(cyc_n - t_csr >= GAP_C, "R8", "cs high gap", cyc_n - t_csr, GAP_C);
                t_csf = cyc_n; nbits = 0;
            end
            if (dac_sclk && !p_sclk) begin
                if (nbits == 0) chk(cyc_n - t_csf == LEAD_C, "R3", "cs fall to first rise", cyc_n - t_csf, LEAD_C);
                else            chk(cyc_n - t_sf == HALF_C, "R2", "sclk low phase", cyc_n - t_sf, HALF_C);
                cap = {cap[14:0], dac_sdo};
                nbits++; t_sr = cyc_n;
            end
            if (!dac_sclk && p_sclk) begin
                chk(cyc_n - t_sr == HALF_C, "R2", "sclk high phase", cyc_n - t_sr, HALF_C);
                t_sf = cyc_n;
            end
            if (dac_cs_n && !p_cs) begin
                chk(cyc_n - t_sf == TAIL_C, "R3", "last fall to cs rise", cyc_n - t_sf, TAIL_C);
                chk(nbits == 16, "R1", "bits per frame", nbits, 16);
                if (exp_q.size() > 0) begin
                    logic [15:0] w;
                    w = exp_q.pop_front();
                    cur_s = exp_s_q.pop_front();
                    chk(cap == w, "R1 R6", "frame word", cap, w);
                end else begin
                    chk(1'b0, "R8", "unexpected frame", 1, 0);
                end
                t_csr = cyc_n; nfr++;
            end
            if (!dac_ld_n && p_ld) begin
                chk(cur_s, "R5", "strobe in cs mode", 1, 0);
                chk(cyc_n - t_csr == LDS_C, "R4", "cs rise to strobe", cyc_n - t_csr, LDS_C);
                t_lf = cyc_n;
            end
            if (dac_ld_n && !p_ld)
                chk(cyc_n - t_lf == LDW_C, "R4", "strobe width", cyc_n - t_lf, LDW_C);
        end
        p_cs = dac_cs_n; p_sclk = dac_sclk; p_ld = dac_ld_n;
    end

    // ---------------- stimulus ----------------
    task automatic check_reset_pins();
        chk(dac_cs_n == 1'b1, "R9", "reset cs_n", dac_cs_n, 1);
        chk(dac_sclk == 1'b0, "R9", "reset sclk", dac_sclk, 0);
        chk(dac_sdo == 1'b0,  "R9", "reset sdo",  dac_sdo,  0);
        chk(dac_ld_n == 1'b1, "R9", "reset ld_n", dac_ld_n, 1);
        chk(code_ready == 1'b0, "R9", "reset ready", code_ready, 0);
    endtask

    task automatic power_up();
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!code_ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == PWR_C, "R7", "power-up lockout cycles", n, PWR_C);
    endtask

    task automatic send(input logic [13:0] c, input bit bip, input bit strb, input logic [15:0] w);
        int busy, lows0;
        @(negedge clk);
        while (!code_ready) @(negedge clk);
        lows0 = ld_lows;
        code_data = c; cfg_bipolar = bip; cfg_strobe = strb; code_valid = 1'b1;
        exp_q.push_back(w); exp_s_q.push_back(strb);
        @(negedge clk);
        code_valid = 1'b0;
        code_data = ~c; cfg_bipolar = !bip; cfg_strobe = !strb;   // R8: ignored while busy
        busy = 0;
        while (!code_ready) begin
            busy++;
            @(negedge clk);
        end
        chk(busy == TOTAL_C, "R8", "busy cycles", busy, TOTAL_C);
        if (!strb) chk(ld_lows == lows0, "R5", "strobe low cycles in cs mode", ld_lows - lows0, 0);
        else       chk(ld_lows - lows0 == LDW_C, "R4", "strobe low cycles", ld_lows - lows0, LDW_C);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
        check_reset_pins();
        power_up();

        send(14'h0000, 1'b0, 1'b0, 16'h0000);
        send(14'h3FFF, 1'b0, 1'b0, 16'hFFFC);
        send(14'h2AAA, 1'b0, 1'b1, 16'hAAA8);
        send(14'h2000, 1'b1, 1'b0, 16'h0000);   // R6 -8192 -> 0x0000
        send(14'h0000, 1'b1, 1'b1, 16'h8000);   // R6 0 -> 0x2000
        send(14'h1FFF, 1'b1, 1'b0, 16'hFFFC);   // R6 8191 -> 0x3FFF
        send(14'h1555, 1'b0, 1'b1, 16'h5554);

        // R9: reset in the middle of a frame
        @(negedge clk);
        while (!code_ready) @(negedge clk);
        code_data = 14'h3C3C; cfg_bipolar = 1'b0; cfg_strobe = 1'b0; code_valid = 1'b1;
        @(negedge clk);
        code_valid = 1'b0;
        repeat (60) @(negedge clk);
        chk(dac_cs_n == 1'b0, "R3", "cs low mid-frame", dac_cs_n, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_pins();
        power_up();
        send(14'h0F0F, 1'b0, 1'b1, 16'h3C3C);

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL R8 watchdog: actual %0d cycles expected completion", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        if (cdiv(50) != HALF_C || cdiv(20000) != PWR_C) $display("bench timing constants inconsistent");
    end
endmodule